// File: doc/BRIEF.md
# Display Line and Pixel Doubler

This block is a 2x integer upscaling stage. It sits between a plane's pixel stream and the display pipe that consumes it. It can repeat every pixel horizontally, repeat every complete line vertically, do both, or do neither. A 2-bit mode code selects which. To repeat a line, the block stores the incoming line in an internal buffer while forwarding it. It then plays the line back a second time from that buffer, holding the upstream source stalled during the playback.

Both the input and the output are valid/ready pixel streams. Each carries a start-of-line flag on the first pixel of a line and an end-of-line flag on the last. A line-width input gives the number of pixels in each source line, and it sets the length of the replayed copy. The mode code is captured only when a start-of-frame pulse arrives. This means a frame is never scaled with a mix of two modes.

Top module: `line_pixel_doubler`

## Requirements
- R1: After reset, the output stream is idle (out_valid low), and the active mode is pass-through (2'b00) until the first start-of-frame pulse.
- R2: Mode 2'b00 forwards each input pixel exactly once. Data, start-of-line and end-of-line are unchanged.
- R3: Mode 2'b11 (pixels only) emits each input pixel twice in a row. Start-of-line is set only on the first copy of a line's first pixel.
- R4: Whenever pixel repetition is active, end-of-line is set only on the second copy of a line's last pixel. Start-of-line and end-of-line are never set on the same output beat.
- R5: Mode 2'b10 (lines only) emits each line twice with the pixels once each. The second copy is played from the line buffer, and in_ready stays low until that copy has been fully sent.
- R6: Mode 2'b01 (both) repeats pixels and lines, so a W x H source frame leaves as exactly 2W x 2H output beats, arranged in 2H lines.
- R7: sof latches mode_i as the active mode. A change on mode_i without a sof pulse has no effect on the output.
- R8: A replayed line is exactly line_width pixels long, for any width from 1 up to the buffer depth MAX_W (2048 by default).
- R9: Under any pattern of out_ready stalls, output beats keep source order, and no beat is dropped or repeated beyond the mode's rule. A stalled replay beat holds its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame pulse, latches mode_i |
| mode_i | input | 2 | Doubling mode: 00 none, 01 both, 10 lines, 11 pixels |
| line_width | input | LW_W (12) | Pixels per source line, 1..MAX_W |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts the input pixel |
| in_data | input | PIX_W (24) | Input pixel value |
| in_sol | input | 1 | Input first pixel of line |
| in_eol | input | 1 | Input last pixel of line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_data | output | PIX_W (24) | Output pixel value |
| out_sol | output | 1 | Output first pixel of line |
| out_eol | output | 1 | Output last pixel of line |

## Verification
If the copy-phase bit is wrong, it appears on the very next output beat: a pixel is missing or tripled, or a line flag sits on the wrong copy. If the replay counter or the buffer write pointer is wrong, the second copy of the line carries the wrong data, typically from its first beat. It also ends early or late, which shows as a displaced end-of-line flag. If the mode register is wrong, the whole next frame has the wrong beat count, starting from its first line. The sweep compares every output beat and its flags against an arithmetically generated frame, so each of these faults is caught at the first beat it affects.

// File: rtl/ldbl_pkg.sv
`timescale 1ns/1ps
package ldbl_pkg;
   typedef enum logic [1:0] {
      DBL_NONE  = 2'b00,
      DBL_BOTH  = 2'b01,
      DBL_LINE  = 2'b10,
      DBL_PIXEL = 2'b11
   } dbl_mode_e;

   typedef enum logic {
      ST_PASS   = 1'b0,
      ST_REPLAY = 1'b1
   } dbl_state_e;

   function automatic logic horiz_on(input dbl_mode_e m);
      return (m == DBL_BOTH) || (m == DBL_PIXEL);
   endfunction

   function automatic logic vert_on(input dbl_mode_e m);
      return (m == DBL_BOTH) || (m == DBL_LINE);
   endfunction
endpackage

// File: rtl/ldbl_mode_reg.sv
`timescale 1ns/1ps
module ldbl_mode_reg
   import ldbl_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sof,
   input  logic [1:0] mode_i,
   output dbl_mode_e mode_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)   mode_q <= DBL_NONE;
      else if (sof) mode_q <= dbl_mode_e'(mode_i);
   end

   // R7
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sof |=> mode_q == $past(mode_q));
endmodule

// File: rtl/ldbl_linebuf.sv
`timescale 1ns/1ps
module ldbl_linebuf #(
   parameter int DATA_W = 24,
   parameter int DEPTH  = 2048,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("ldbl_linebuf: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
   end

   assign rd_data = store[rd_addr];
endmodule

// File: rtl/line_pixel_doubler.sv
`timescale 1ns/1ps
module line_pixel_doubler
   import ldbl_pkg::*;
#(
   parameter int PIX_W  = 24,
   parameter int MAX_W  = 2048,
   localparam int ADDR_W = $clog2(MAX_W),
   localparam int LW_W   = $clog2(MAX_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof,
   input  logic [1:0]        mode_i,
   input  logic [LW_W-1:0]   line_width,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [PIX_W-1:0]  in_data,
   input  logic              in_sol,
   input  logic              in_eol,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [PIX_W-1:0]  out_data,
   output logic              out_sol,
   output logic              out_eol
);
   generate
      if (PIX_W < 1) begin : g_bad_pix
         $error("line_pixel_doubler: PIX_W must be positive");
      end
      if (LW_W != ADDR_W + 1) begin : g_bad_width
         $error("line_pixel_doubler: MAX_W must be a power of two");
      end
   endgenerate

   dbl_mode_e  mode_q;
   dbl_state_e state;
   logic              hphase;
   logic [ADDR_W-1:0] wptr, rcnt, wr_addr;
   logic [PIX_W-1:0]  rd_data;
   logic h_dbl, v_dbl, second, last_rep, in_fire, out_fire;

   ldbl_mode_reg u_mode (
      .clk(clk), .rst_n(rst_n), .sof(sof), .mode_i(mode_i), .mode_q(mode_q)
   );

   assign wr_addr = in_sol ? '0 : wptr;

   ldbl_linebuf #(.DATA_W(PIX_W), .DEPTH(MAX_W)) u_buf (
      .clk(clk), .wr_en(in_fire), .wr_addr(wr_addr), .wr_data(in_data),
      .rd_addr(rcnt), .rd_data(rd_data)
   );

   assign h_dbl    = horiz_on(mode_q);
   assign v_dbl    = vert_on(mode_q);
   assign second   = !h_dbl || hphase;
   assign last_rep = ({1'b0, rcnt} == line_width - 1'b1);

   always_comb begin
      if (state == ST_PASS) begin
         out_valid = in_valid;
         out_data  = in_data;
         out_sol   = in_sol && !hphase;
         out_eol   = in_eol && second;
         in_ready  = out_ready && second;
      end else begin
         out_valid = 1'b1;
         out_data  = rd_data;
         out_sol   = (rcnt == '0) && !hphase;
         out_eol   = last_rep && second;
         in_ready  = 1'b0;
      end
   end

   assign in_fire  = in_valid && in_ready;
   assign out_fire = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_PASS;
         hphase <= 1'b0;
         rcnt   <= '0;
         wptr   <= '0;
      end else begin
         if (out_fire && h_dbl) hphase <= !hphase;
         if (state == ST_PASS) begin
            if (in_fire) wptr <= wr_addr + 1'b1;
            if (in_fire && in_eol && v_dbl) begin
               state <= ST_REPLAY;
               rcnt  <= '0;
            end
         end else if (out_fire && second) begin
            if (last_rep) begin
               state <= ST_PASS;
               rcnt  <= '0;
            end else begin
               rcnt <= rcnt + 1'b1;
            end
         end
      end
   end

   // R5
   replay_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_REPLAY |-> !in_ready);

   // R5
   replay_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_fire && in_eol && v_dbl |=> out_valid && out_sol);

   // R4
   flag_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && h_dbl |-> !(out_sol && out_eol));

   // R8
   replay_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_REPLAY |-> {1'b0, rcnt} < line_width);

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_REPLAY && out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: tb/tb_line_pixel_doubler.sv
`timescale 1ns/1ps
module tb_line_pixel_doubler;
   localparam int PIX_W = 24;
   localparam int MAX_W = 2048;
   localparam int LW_W  = $clog2(MAX_W + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sof = 1'b0;
   logic [1:0] mode_i = 2'b00;
   logic [LW_W-1:0] line_width = '0;
   logic in_valid = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
   logic [PIX_W-1:0] in_data = '0;
   logic out_ready = 1'b1;
   logic in_ready, out_valid, out_sol, out_eol;
   logic [PIX_W-1:0] out_data;

   int n_checks = 0, n_fail = 0, out_cnt = 0;
   bit stall_en = 1'b0, done = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   string cur_req = "R2";
   logic [PIX_W+1:0] exp_q[$];

   always #2.5 clk = ~clk;

   line_pixel_doubler #(.PIX_W(PIX_W), .MAX_W(MAX_W)) dut (
      .clk(clk), .rst_n(rst_n), .sof(sof), .mode_i(mode_i), .line_width(line_width),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_sol(in_sol), .in_eol(in_eol),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_sol(out_sol), .out_eol(out_eol)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
   end

   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         out_cnt++;
         if (exp_q.size() == 0) begin
            check(1'b0, {cur_req, " R9 extra beat"}, {out_sol, out_eol, out_data}, 0);
         end else begin
            logic [PIX_W+1:0] e;
            e = exp_q.pop_front();
            check({out_sol, out_eol, out_data} == e, cur_req,
                  {out_sol, out_eol, out_data}, e);
         end
      end
   end

   // mode encoding: 00 none, 01 both, 10 lines, 11 pixels
   task automatic build_expected(input logic [1:0] m, input int w, input int h);
      bit hd = (m == 2'b01) || (m == 2'b11);
      bit vd = (m == 2'b01) || (m == 2'b10);
      int ow = hd ? 2 * w : w;
      int oh = vd ? 2 * h : h;
      for (int ol = 0; ol < oh; ol++) begin
         for (int oc = 0; oc < ow; oc++) begin
            int sl = vd ? ol / 2 : ol;
            int sc = hd ? oc / 2 : oc;
            logic [PIX_W-1:0] d = PIX_W'((sl << 12) | sc);
            exp_q.push_back({oc == 0, oc == ow - 1, d});
         end
      end
   endtask

   task automatic send_px(input int ln, input int col, input int w);
      if (stall_en && lfsr[5] && lfsr[7]) begin
         @(posedge clk); #1;
      end
      in_valid = 1'b1;
      in_data  = PIX_W'((ln << 12) | col);
      in_sol   = (col == 0);
      in_eol   = (col == w - 1);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_sol   = 1'b0;
      in_eol   = 1'b0;
   endtask

   task automatic run_frame(input logic [1:0] m_latch, input logic [1:0] m_after,
                            input int w, input int h, input bit stall, input string req);
      int guard = 0;
      int want;
      cur_req  = req;
      stall_en = stall;
      line_width = LW_W'(w);
      mode_i = m_latch;
      sof = 1'b1;
      @(posedge clk); #1;
      sof = 1'b0;
      mode_i = m_after;
      out_cnt = 0;
      build_expected(m_latch, w, h);
      want = exp_q.size();
      for (int ln = 0; ln < h; ln++)
         for (int c = 0; c < w; c++) send_px(ln, c, w);
      while (exp_q.size() != 0 && guard < 50000) begin
         @(negedge clk);
         guard++;
      end
      repeat (4) @(negedge clk);
      check(out_cnt == want, {req, " frame beat count"}, out_cnt, want);
      exp_q.delete();
      @(posedge clk); #1;
   endtask

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check(out_valid == 1'b0, "R1 idle after release", out_valid, 0);
      check(in_ready == 1'b1, "R1 pass-through ready", in_ready, 1);

      run_frame(2'b00, 2'b00, 4, 3, 1'b0, "R2");
      run_frame(2'b00, 2'b00, 5, 2, 1'b1, "R2 R9");
      run_frame(2'b11, 2'b11, 3, 2, 1'b1, "R3 R4");
      run_frame(2'b11, 2'b11, 1, 2, 1'b0, "R4");
      run_frame(2'b10, 2'b10, 4, 3, 1'b1, "R5 R9");
      run_frame(2'b10, 2'b10, 1, 2, 1'b1, "R5");
      run_frame(2'b01, 2'b01, 3, 3, 1'b1, "R6 R9");
      run_frame(2'b01, 2'b01, 1, 1, 1'b0, "R6");
      run_frame(2'b01, 2'b00, 3, 2, 1'b1, "R7 latched");
      run_frame(2'b00, 2'b11, 2, 2, 1'b0, "R7 relatched");
      run_frame(2'b01, 2'b01, MAX_W, 1, 1'b0, "R8 full width");
      run_frame(2'b10, 2'b10, 7, 2, 1'b1, "R8");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule